// File: doc/BRIEF.md
# Wake-up Event Status Register

This block gathers the wake-up causes of an embedded controller into two 8-bit status registers that the local processor reads over a small register bus. The first register (address 0, the "event" register) latches one-cycle event pulses: an alarm that fires when the real-time clock reaches its alarm setting, start-condition detects from two serial buses, and a strobe that marks a host write to a power-management register. Reading it returns its contents and empties it. The second register (address 1, the "timer/key" register) holds the hibernation-timer expiry flag and the any-key flag from the keyboard scan inputs. Software clears either flag by writing 1 to its bit.

The alarm input is a level that stays high while the clock equals the alarm setting. A two-state machine turns that level into a single event. In state ALM_WAIT, a high match level emits one alarm pulse and moves to ALM_HELD. In state ALM_HELD, the machine stays put while the match holds and returns to ALM_WAIT when it drops. A read during a long match therefore leaves the bit clear. The eight active-low scan lines pass through a two-flop synchronizer and are then combined: the any-key condition is true when at least one line is low. The block drives a wake request whenever any status bit is set.

Top module: `wake_status_regs`

## Requirements
- R1: After reset, both registers read 0x00, `wake_req` is 0 and `rdata` is 0x00.
- R2: Event register bit 0 is set in the clock edge at which `rtc_match` is first sampled high after being low (or after reset). While `rtc_match` stays high, no further set occurs, so after a read clears the bit it stays 0 until `rtc_match` has gone low and then high again.
- R3: A read of address 0 returns the event register and clears it at the end of that read cycle. An event that arrives in the same cycle is kept and reads back on the next read.
- R4: A pulse on `bus1_start` sets event bit 4 (0x10), a pulse on `bus2_start` sets bit 3 (0x08) and a pulse on `pm1_wr` sets bit 5 (0x20). Each is set at the edge that samples the pulse.
- R5: Timer/key bit 2 (0x04) is set at an edge where `hib_en` and `hib_zero` are both high. When `hib_en` is low, `hib_zero` has no effect.
- R6: Timer/key bit 1 (0x02) is set when any `ksi_n` line is low and `key_mask` is 0. A change on `ksi_n` made before edge k sets the bit at edge k+2. When `key_mask` is 1, low lines do not set it.
- R7: Writing address 1 clears each of bits 2 and 1 whose `wdata` bit is 1. A 0 in `wdata` leaves the bit alone, and reads of address 1 do not clear it. A set condition in the same cycle as the clearing write wins, and the bit stays 1.
- R8: Bits 7..3 and 0 of the timer/key register, and bits 7, 6, 2 and 1 of the event register, always read 0. A write to address 0 changes nothing.
- R9: `wake_req` is 1 exactly when either register holds a nonzero value.
- R10: `rdata` presents the addressed register (address 0 for event, 1 for timer/key) combinationally while `rd_en` is high, and shows 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rtc_match | input | 1 | High while the clock time equals the alarm setting |
| hib_en | input | 1 | Hibernation timer enabled |
| hib_zero | input | 1 | Hibernation count has reached zero |
| ksi_n | input | 8 | Keyboard scan-in lines, active low, asynchronous |
| key_mask | input | 1 | 1 blocks the any-key flag from setting |
| bus1_start | input | 1 | Start/event detect pulse, serial bus 1 |
| bus2_start | input | 1 | Start/event detect pulse, serial bus 2 |
| pm1_wr | input | 1 | Host wrote a power-management register |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 event, 1 timer/key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| wake_req | output | 1 | Wake request, any status bit set |

## Verification
Every status bit except the any-key flag becomes visible after the single edge that samples its cause. The any-key flag needs two extra edges for the synchronizer, and a read or write takes effect at the edge that closes its cycle, while read data is valid before that edge. The bench drives all inputs on the falling edge and samples `rdata` and `wake_req` shortly after the falling edge. It counts the rising edges to each result and checks the key flag once before and once after its third edge. The race cases assert the event and the clear in one cycle and read back the result on the following access.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int REG_W = 8;
    localparam int KEY_W = 8;

    // event register bit positions
    localparam int EV_ALARM = 0;
    localparam int EV_BUS2  = 3;
    localparam int EV_BUS1  = 4;
    localparam int EV_PM1   = 5;
    // timer/key register bit positions
    localparam int TK_KEY   = 1;
    localparam int TK_HIB   = 2;

    localparam logic [REG_W-1:0] EV_VALID = (REG_W'(1) << EV_ALARM) | (REG_W'(1) << EV_BUS2)
                                          | (REG_W'(1) << EV_BUS1)  | (REG_W'(1) << EV_PM1);
    localparam logic [REG_W-1:0] TK_VALID = (REG_W'(1) << TK_KEY) | (REG_W'(1) << TK_HIB);

    typedef enum logic {
        ALM_WAIT = 1'b0,
        ALM_HELD = 1'b1
    } alm_state_t;

    typedef enum logic {
        CLR_ON_READ = 1'b0,
        CLR_W1C     = 1'b1
    } clr_mode_t;
endpackage

// File: rtl/wake_key_sync.sv
module wake_key_sync #(
    parameter int KEY_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] ksi_n,
    output logic             any_key
);
    logic [KEY_W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= ksi_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // any line low -> key activity
    assign any_key = ~(&stage_q[STAGES-1]);
endmodule

// File: rtl/wake_alarm_edge.sv
module wake_alarm_edge
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    output logic fire
);
    alm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ALM_WAIT: if (match) begin
                fire    = 1'b1;
                state_d = ALM_HELD;
            end
            ALM_HELD: if (!match) state_d = ALM_WAIT;
            default:  state_d = ALM_WAIT;
        endcase
    end

    AST_ALM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R2
    AST_ALM_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(match) && $past(rst_n)) |-> !fire); // R2
endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank
    import wake_pkg::*;
#(
    parameter int              W     = 8,
    parameter logic [W-1:0]    VALID = '1,
    parameter clr_mode_t       MODE  = CLR_ON_READ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] q_d;

    always_comb begin
        if (MODE == CLR_ON_READ) clr_vec = rd_hit ? {W{1'b1}} : '0;
        else                     clr_vec = (wr_hit && !rd_hit) ? wdata : (wr_hit ? wdata : '0);
        // set beats clear
        q_d = ((q & ~clr_vec) | set_vec) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~VALID) == '0); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((q & $past(set_vec & VALID)) == $past(set_vec & VALID))); // R3
endmodule

// File: rtl/wake_status_regs.sv
module wake_status_regs
    import wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_match,
    input  logic             hib_en,
    input  logic             hib_zero,
    input  logic [KEY_W-1:0] ksi_n,
    input  logic             key_mask,
    input  logic             bus1_start,
    input  logic             bus2_start,
    input  logic             pm1_wr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             wake_req
);
    logic             alarm_fire;
    logic             any_key;
    logic [REG_W-1:0] ev_set, tk_set;
    logic [REG_W-1:0] ev_q, tk_q;
    logic             ev_rd, tk_wr;

    wake_alarm_edge u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .match (rtc_match),
        .fire  (alarm_fire)
    );

    wake_key_sync #(.KEY_W(KEY_W), .STAGES(2)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .ksi_n   (ksi_n),
        .any_key (any_key)
    );

    always_comb begin
        ev_set = '0;
        ev_set[EV_ALARM] = alarm_fire;
        ev_set[EV_BUS2]  = bus2_start;
        ev_set[EV_BUS1]  = bus1_start;
        ev_set[EV_PM1]   = pm1_wr;
        tk_set = '0;
        tk_set[TK_HIB]   = hib_en & hib_zero;
        tk_set[TK_KEY]   = any_key & ~key_mask;
    end

    assign ev_rd = rd_en & ~addr;
    assign tk_wr = wr_en & addr;

    wake_status_bank #(.W(REG_W), .VALID(EV_VALID), .MODE(CLR_ON_READ)) u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ev_set),
        .rd_hit  (ev_rd),
        .wr_hit  (1'b0),
        .wdata   (wdata),
        .q       (ev_q)
    );

    wake_status_bank #(.W(REG_W), .VALID(TK_VALID), .MODE(CLR_W1C)) u_tk (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (tk_set),
        .rd_hit  (1'b0),
        .wr_hit  (tk_wr),
        .wdata   (wdata),
        .q       (tk_q)
    );

    always_comb begin
        if (!rd_en)    rdata = '0;
        else if (addr) rdata = tk_q;
        else           rdata = ev_q;
    end

    assign wake_req = (|ev_q) | (|tk_q);

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && ev_set == '0) |=> (ev_q == '0)); // R3
    AST_BUS1_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        bus1_start |=> ev_q[EV_BUS1]); // R4
    AST_HIB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hib_en && hib_zero) |=> tk_q[TK_HIB]); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_wr && wdata[TK_HIB] && !(hib_en && hib_zero)) |=> !tk_q[TK_HIB]); // R7
    AST_TK_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr && !wr_en) |=> ((tk_q & $past(tk_q)) == $past(tk_q))); // R7
    AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req == ((ev_q != '0) || (tk_q != '0))); // R9
endmodule

// File: tb/wake_status_regs_test.sv
module wake_status_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_match = 0, hib_en = 0, hib_zero = 0, key_mask = 0;
    logic [7:0] ksi_n = 8'hFF;
    logic       bus1_start = 0, bus2_start = 0, pm1_wr = 0;
    logic       rd_en = 0, wr_en = 0, addr = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wake_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    wake_status_regs uut (
        .clk(clk), .rst_n(rst_n), .rtc_match(rtc_match), .hib_en(hib_en),
        .hib_zero(hib_zero), .ksi_n(ksi_n), .key_mask(key_mask),
        .bus1_start(bus1_start), .bus2_start(bus2_start), .pm1_wr(pm1_wr),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // read: data sampled before the closing edge
    task automatic do_read(input logic a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick();
        sig = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        #1;
        check("R1 rdata idle", rdata, 8'h00);
        check("R1 wake_req", {7'b0, wake_req}, 8'h00);
        do_read(1'b0, d); check("R1 event reg", d, 8'h00);
        do_read(1'b1, d); check("R1 timer/key reg", d, 8'h00);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        rtc_match = 1'b1;
        tick();
        do_read(1'b0, d); check("R2 alarm edge sets", d, 8'h01);
        tick(3);
        do_read(1'b0, d); check("R2 held match no reset", d, 8'h00);
        rtc_match = 1'b0;
        tick(2);
        rtc_match = 1'b1;
        tick();
        rtc_match = 1'b0;
        do_read(1'b0, d); check("R2 new edge sets", d, 8'h01);
    endtask

    task automatic t_read_race();
        logic [7:0] d;
        pulse(bus1_start);
        bus2_start = 1'b1;
        do_read(1'b0, d);
        bus2_start = 1'b0;
        check("R3 read returns prior", d, 8'h10);
        do_read(1'b0, d); check("R3 same-cycle event kept", d, 8'h08);
        do_read(1'b0, d); check("R3 cleared after read", d, 8'h00);
    endtask

    task automatic t_sources();
        logic [7:0] d;
        pulse(pm1_wr);
        do_read(1'b0, d); check("R4 pm1 bit5", d, 8'h20);
        pulse(bus1_start);
        pulse(bus2_start);
        do_read(1'b0, d); check("R4 bus bits", d, 8'h18);
    endtask

    task automatic t_hib();
        logic [7:0] d;
        hib_zero = 1'b1;
        tick(2);
        do_read(1'b1, d); check("R5 disabled timer ignored", d, 8'h00);
        hib_en = 1'b1;
        tick();
        hib_en = 1'b0; hib_zero = 1'b0;
        do_read(1'b1, d); check("R5 timer expiry", d, 8'h04);
        do_read(1'b1, d); check("R7 read keeps", d, 8'h04);
        do_write(1'b1, 8'h00);
        do_read(1'b1, d); check("R7 write 0 no effect", d, 8'h04);
        hib_en = 1'b1; hib_zero = 1'b1;
        do_write(1'b1, 8'h04);
        hib_en = 1'b0; hib_zero = 1'b0;
        do_read(1'b1, d); check("R7 set beats clear", d, 8'h04);
        do_write(1'b1, 8'h04);
        do_read(1'b1, d); check("R7 write 1 clears", d, 8'h00);
    endtask

    task automatic t_keys();
        logic [7:0] d;
        key_mask = 1'b1;
        ksi_n = 8'hFE;
        tick(4);
        do_read(1'b1, d); check("R6 masked keys ignored", d, 8'h00);
        ksi_n = 8'hFF;
        tick(3);
        key_mask = 1'b0;
        ksi_n = 8'hEF;
        tick(2);
        addr = 1'b1; rd_en = 1'b1;
        #1 check("R6 not before third edge", rdata, 8'h00);
        tick();
        rd_en = 1'b0;
        ksi_n = 8'hFF;
        do_read(1'b1, d); check("R6 any key sets", d, 8'h02);
        tick(3);
        do_write(1'b1, 8'h02);
        do_read(1'b1, d); check("R7 key bit cleared", d, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        do_write(1'b1, 8'hFF);
        do_read(1'b1, d); check("R8 reserved tk bits", d, 8'h00);
        pulse(bus1_start);
        do_write(1'b0, 8'hFF);
        do_read(1'b0, d); check("R8 event reg not writable", d, 8'h10);
        do_write(1'b0, 8'hFF);
        do_read(1'b0, d); check("R8 event write sets nothing", d, 8'h00);
    endtask

    task automatic t_wake();
        logic [7:0] d;
        #1 check("R9 idle no wake", {7'b0, wake_req}, 8'h00);
        pulse(pm1_wr);
        #1 check("R9 event wakes", {7'b0, wake_req}, 8'h01);
        do_read(1'b0, d);
        #1 check("R9 cleared no wake", {7'b0, wake_req}, 8'h00);
        hib_en = 1'b1; hib_zero = 1'b1;
        tick();
        hib_en = 1'b0; hib_zero = 1'b0;
        #1 check("R9 timer wakes", {7'b0, wake_req}, 8'h01);
        rd_en = 1'b0; addr = 1'b1;
        #1 check("R10 no strobe zero", rdata, 8'h00);
        rd_en = 1'b1;
        #1 check("R10 addressed reg", rdata, 8'h04);
        rd_en = 1'b0;
        do_write(1'b1, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alarm();
        t_read_race();
        t_sources();
        t_hib();
        t_keys();
        t_reserved();
        t_wake();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule